// File: doc/BRIEF.md
# Management-Mode Resume Engine

This block carries out the return from system management mode. On a resume command it reads a fixed set of 32-bit words back from the state-save area through a simple memory read port. The save area starts at the management base plus 0xFE00. From those words it rebuilds the register values the core reloads: the new management base, the control word, the flags, the instruction pointer, and three data segments (ES, SS and DS) with their selectors and attribute words. It also derives the privilege level and the per-segment validity and default-size bits.

When the last word has arrived, the block pulses a load strobe, and in the same cycle a release pulse that tells the core to drop the management-active indication and its in-mode flag. The block also holds the NMI gate. While the core is in management mode, NMI requests are latched rather than taken. An NMI that was latched this way is replayed as a trap request right after the return. A resume command issued outside management mode reads nothing and asks for an invalid-opcode trap.

Top module: `smm_resume_engine`

## Requirements
- R1: A `rsm_cmd` pulse while `in_smm` is low and the engine is idle issues no read and raises `ud_trap` (invalid-opcode, vector 6) for exactly one cycle, in the cycle after the command.
- R2: Reads go to `smbase_in` + 0xFE00 + offset, with `smbase_in` sampled at the command. The order is fixed: 0xF8 (base), 0x1FC (control word), 0x1F4 (flags), 0x1F0 (instruction pointer), then ES selector 0x1A8 and attribute 0x138, SS selector 0x1B0 and attribute 0x150, DS selector 0x1B4 and attribute 0x15C.
- R3: `rd_req` is a one-cycle pulse. At most one read is outstanding at a time, and the next request follows only after `rd_valid` returns the data.
- R4: `ld_strobe` pulses for one cycle, in the cycle after the last `rd_valid`. In that cycle `new_smbase`, `new_cr0`, `new_eflags` and `new_eip` carry the restored words; `new_smbase` comes from offset 0xF8.
- R5: `new_cpl` equals bits 14:13 of the restored SS attribute word.
- R6: When restored control bit 0 is 1 and restored flags bit 17 is 0, a segment is valid only if the low 16 bits of its selector are nonzero, and its default-size bit is attribute bit 14. Segment index 0 is ES, 1 is SS and 2 is DS, in `seg_valid`, `seg_dsize` and in 16-bit slices of `seg_sel`.
- R7: Otherwise (real mode, or virtual-8086 mode) every segment is valid and every default-size bit is 0.
- R8: `smiact_release` pulses together with `ld_strobe`, and the NMI mask is clear from the next cycle on.
- R9: The NMI mask is set in the cycle after `in_smm` rises. While it is set, an `nmi_req` pulse raises no trap and sets `nmi_pending`.
- R10: If `nmi_pending` is set at the load strobe, `nmi_trap` (vector 2) pulses once in the next cycle and `nmi_pending` clears. With nothing pending, no trap follows the resume.
- R11: An `nmi_req` pulse while the mask is clear raises `nmi_trap` in the next cycle and does not set `nmi_pending`.
- R12: A `rsm_cmd` while a resume is in progress is ignored. The read sequence goes on unchanged and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsm_cmd | input | 1 | Resume command pulse |
| in_smm | input | 1 | Core is in management mode |
| smbase_in | input | ADDR_W | Current management base |
| nmi_req | input | 1 | NMI request pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| ld_strobe | output | 1 | Restored values valid, load now |
| new_smbase | output | 32 | Restored management base |
| new_cr0 | output | 32 | Restored control word |
| new_eflags | output | 32 | Restored flags |
| new_eip | output | 32 | Restored instruction pointer |
| new_cpl | output | 2 | Derived privilege level |
| seg_sel | output | 48 | Selectors, 16 bits per segment |
| seg_attr | output | 96 | Attribute words, 32 bits per segment |
| seg_valid | output | 3 | Segment valid bits |
| seg_dsize | output | 3 | Segment default-size bits |
| smiact_release | output | 1 | Drop management-active and in-mode flag |
| ud_trap | output | 1 | Invalid-opcode trap request |
| nmi_trap | output | 1 | NMI trap request |
| nmi_masked | output | 1 | NMI mask state |
| nmi_pending | output | 1 | NMI latched while masked |

## Verification
A wrong read index shows at once, as a mismatched `rd_addr` on the first request it affects. A capture into the wrong word shows only at the load strobe, as a wrong restored value or a wrong valid, size or privilege bit. A mask or pending flag stuck in the wrong state shows one cycle after the next NMI request or one cycle after the strobe, as a missing, extra or duplicated `nmi_trap`. A stuck sequencer shows as `rd_req` held across cycles, or as a strobe that never comes.

// File: rtl/smm_rsm_pkg.sv
package smm_rsm_pkg;

    localparam int WORD_W    = 32;
    localparam int SEL_W     = 16;
    localparam int NUM_SEG   = 3;               // 0: ES, 1: SS, 2: DS
    localparam int NUM_SLOTS = 4 + 2 * NUM_SEG;
    localparam int SLOT_IW   = $clog2(NUM_SLOTS);

    // word positions in capture order
    localparam int SL_BASE  = 0;
    localparam int SL_CR0   = 1;
    localparam int SL_FLAGS = 2;
    localparam int SL_IP    = 3;
    localparam int SL_SEG0  = 4;
    localparam int SEG_SS   = 1;

    localparam int PE_BIT    = 0;
    localparam int VM_BIT    = 17;
    localparam int CPL_LO    = 13;
    localparam int DSIZE_BIT = 14;

    localparam logic [15:0] SAVE_AREA_OFS = 16'hFE00;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_FINISH
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0]          smbase;
        logic [WORD_W-1:0]          cr0;
        logic [WORD_W-1:0]          eflags;
        logic [WORD_W-1:0]          eip;
        logic [1:0]                 cpl;
        logic [NUM_SEG*SEL_W-1:0]   sel;
        logic [NUM_SEG*WORD_W-1:0]  attr;
        logic [NUM_SEG-1:0]         valid;
        logic [NUM_SEG-1:0]         dsize;
    } restore_bundle_t;

    // save-map offset of each capture slot; the save layout is fixed
    function automatic logic [11:0] slot_offset(input int idx);
        case (idx)
            0:       return 12'h0F8;
            1:       return 12'h1FC;
            2:       return 12'h1F4;
            3:       return 12'h1F0;
            4:       return 12'h1A8;
            5:       return 12'h138;
            6:       return 12'h1B0;
            7:       return 12'h150;
            8:       return 12'h1B4;
            9:       return 12'h15C;
            default: return 12'h000;
        endcase
    endfunction

endpackage

// File: rtl/rsm_sequencer.sv
module rsm_sequencer
    import smm_rsm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rsm_cmd,
    input  logic                          in_smm,
    input  logic [ADDR_W-1:0]             smbase_in,
    output logic                          rd_req,
    output logic [ADDR_W-1:0]             rd_addr,
    input  logic                          rd_valid,
    input  logic [WORD_W-1:0]             rd_data,
    output logic [NUM_SLOTS*WORD_W-1:0]   words,
    output logic                          finish,
    output logic                          ud_trap,
    output logic                          busy
);

    localparam logic [SLOT_IW-1:0] LAST_IDX = SLOT_IW'(NUM_SLOTS - 1);

    seq_state_e          st;
    logic [SLOT_IW-1:0]  idx;
    logic [ADDR_W-1:0]   area_q;
    logic [WORD_W-1:0]   word_q [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            idx     <= '0;
            area_q  <= '0;
            ud_trap <= 1'b0;
            for (int k = 0; k < NUM_SLOTS; k++) word_q[k] <= '0;
        end else begin
            ud_trap <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (rsm_cmd) begin
                        if (in_smm) begin
                            st     <= SQ_ISSUE;
                            idx    <= '0;
                            area_q <= smbase_in + ADDR_W'(SAVE_AREA_OFS);
                        end else begin
                            ud_trap <= 1'b1;
                        end
                    end
                end
                SQ_ISSUE: st <= SQ_WAIT;
                SQ_WAIT: begin
                    if (rd_valid) begin
                        word_q[idx] <= rd_data;
                        if (idx == LAST_IDX) begin
                            st <= SQ_FINISH;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= SQ_ISSUE;
                        end
                    end
                end
                SQ_FINISH: st <= SQ_IDLE;
                default:   st <= SQ_IDLE;
            endcase
        end
    end

    assign rd_req  = (st == SQ_ISSUE);
    assign rd_addr = area_q + ADDR_W'(slot_offset(int'(idx)));
    assign finish  = (st == SQ_FINISH);
    assign busy    = (st != SQ_IDLE);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flat
        assign words[g*WORD_W +: WORD_W] = word_q[g];
    end

endmodule

// File: rtl/rsm_decode.sv
module rsm_decode
    import smm_rsm_pkg::*;
(
    input  logic [NUM_SLOTS*WORD_W-1:0] words,
    output restore_bundle_t             bundle
);

    logic [WORD_W-1:0]          w [NUM_SLOTS];
    logic                       prot_act;
    logic [NUM_SEG*SEL_W-1:0]   sel_v;
    logic [NUM_SEG*WORD_W-1:0]  attr_v;
    logic [NUM_SEG-1:0]         valid_v;
    logic [NUM_SEG-1:0]         dsize_v;
    logic [NUM_SEG*(WORD_W-SEL_W)-1:0] unused_sel_hi;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_split
        assign w[g] = words[g*WORD_W +: WORD_W];
    end

    // mode is taken from the restored words, not the pre-resume state
    assign prot_act = w[SL_CR0][PE_BIT] & ~w[SL_FLAGS][VM_BIT];

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        localparam int SEL_IDX  = SL_SEG0 + 2 * s;
        localparam int ATTR_IDX = SL_SEG0 + 2 * s + 1;
        assign sel_v[s*SEL_W +: SEL_W]    = w[SEL_IDX][SEL_W-1:0];
        assign unused_sel_hi[s*(WORD_W-SEL_W) +: (WORD_W-SEL_W)] = w[SEL_IDX][WORD_W-1:SEL_W];
        assign attr_v[s*WORD_W +: WORD_W] = w[ATTR_IDX];
        assign valid_v[s] = prot_act ? (w[SEL_IDX][SEL_W-1:0] != '0) : 1'b1;
        assign dsize_v[s] = prot_act & w[ATTR_IDX][DSIZE_BIT];
    end

    assign bundle = '{
        smbase: w[SL_BASE],
        cr0:    w[SL_CR0],
        eflags: w[SL_FLAGS],
        eip:    w[SL_IP],
        cpl:    w[SL_SEG0 + 2*SEG_SS + 1][CPL_LO +: 2],
        sel:    sel_v,
        attr:   attr_v,
        valid:  valid_v,
        dsize:  dsize_v
    };

endmodule

// File: rtl/nmi_gate.sv
module nmi_gate (
    input  logic clk,
    input  logic rst,
    input  logic in_smm,
    input  logic nmi_req,
    input  logic release_i,
    output logic nmi_trap,
    output logic masked,
    output logic pending
);

    logic in_smm_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_smm_d <= 1'b0;
            masked   <= 1'b0;
            pending  <= 1'b0;
            nmi_trap <= 1'b0;
        end else begin
            in_smm_d <= in_smm;
            if (release_i) begin
                masked   <= 1'b0;
                pending  <= 1'b0;
                nmi_trap <= pending | nmi_req;
            end else begin
                if (in_smm && !in_smm_d) masked <= 1'b1;
                if (masked && nmi_req)   pending <= 1'b1;
                nmi_trap <= nmi_req & ~masked;
            end
        end
    end

endmodule

// File: rtl/smm_resume_engine.sv
module smm_resume_engine
    import smm_rsm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rsm_cmd,
    input  logic                          in_smm,
    input  logic [ADDR_W-1:0]             smbase_in,
    input  logic                          nmi_req,
    output logic                          rd_req,
    output logic [ADDR_W-1:0]             rd_addr,
    input  logic                          rd_valid,
    input  logic [WORD_W-1:0]             rd_data,
    output logic                          ld_strobe,
    output logic [WORD_W-1:0]             new_smbase,
    output logic [WORD_W-1:0]             new_cr0,
    output logic [WORD_W-1:0]             new_eflags,
    output logic [WORD_W-1:0]             new_eip,
    output logic [1:0]                    new_cpl,
    output logic [NUM_SEG*SEL_W-1:0]      seg_sel,
    output logic [NUM_SEG*WORD_W-1:0]     seg_attr,
    output logic [NUM_SEG-1:0]            seg_valid,
    output logic [NUM_SEG-1:0]            seg_dsize,
    output logic                          smiact_release,
    output logic                          ud_trap,
    output logic                          nmi_trap,
    output logic                          nmi_masked,
    output logic                          nmi_pending
);

    logic [NUM_SLOTS*WORD_W-1:0] words;
    logic                        finish;
    logic                        busy;
    restore_bundle_t             bundle;

    rsm_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .rsm_cmd   (rsm_cmd),
        .in_smm    (in_smm),
        .smbase_in (smbase_in),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .words     (words),
        .finish    (finish),
        .ud_trap   (ud_trap),
        .busy      (busy)
    );

    rsm_decode u_dec (
        .words  (words),
        .bundle (bundle)
    );

    nmi_gate u_nmi (
        .clk       (clk),
        .rst       (rst),
        .in_smm    (in_smm),
        .nmi_req   (nmi_req),
        .release_i (finish),
        .nmi_trap  (nmi_trap),
        .masked    (nmi_masked),
        .pending   (nmi_pending)
    );

    assign ld_strobe      = finish;
    assign smiact_release = finish;
    assign new_smbase     = bundle.smbase;
    assign new_cr0        = bundle.cr0;
    assign new_eflags     = bundle.eflags;
    assign new_eip        = bundle.eip;
    assign new_cpl        = bundle.cpl;
    assign seg_sel        = bundle.sel;
    assign seg_attr       = bundle.attr;
    assign seg_valid      = bundle.valid;
    assign seg_dsize      = bundle.dsize;

endmodule

// File: rtl/smm_resume_engine_chk.sv
module smm_resume_engine_chk (
    input logic clk,
    input logic rst,
    input logic rsm_cmd,
    input logic in_smm,
    input logic busy,
    input logic rd_req,
    input logic ld_strobe,
    input logic ud_trap,
    input logic nmi_req,
    input logic nmi_trap,
    input logic nmi_masked,
    input logic nmi_pending
);

    p_ud_no_read_r1: assert property (@(posedge clk) disable iff (rst)
        (rsm_cmd && !in_smm && !busy) |=> (ud_trap && !rd_req));

    p_single_outstanding_r3: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        ld_strobe |=> !ld_strobe);

    p_mask_release_r8: assert property (@(posedge clk) disable iff (rst)
        ld_strobe |=> !nmi_masked);

    p_masked_latch_r9: assert property (@(posedge clk) disable iff (rst)
        (nmi_masked && nmi_req && !ld_strobe) |=> (!nmi_trap && nmi_pending));

    p_replay_r10: assert property (@(posedge clk) disable iff (rst)
        (ld_strobe && nmi_pending) |=> (nmi_trap && !nmi_pending));

    p_unmasked_trap_r11: assert property (@(posedge clk) disable iff (rst)
        (!nmi_masked && nmi_req && !ld_strobe) |=> (nmi_trap && !nmi_pending));

    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && rsm_cmd) |=> !ud_trap);

endmodule

bind smm_resume_engine smm_resume_engine_chk u_chk (.*);

// File: tb/smm_resume_engine_test.sv
module smm_resume_engine_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        rsm_cmd;
    logic        in_smm;
    logic [31:0] smbase_in;
    logic        nmi_req;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        ld_strobe;
    logic [31:0] new_smbase, new_cr0, new_eflags, new_eip;
    logic [1:0]  new_cpl;
    logic [47:0] seg_sel;
    logic [95:0] seg_attr;
    logic [2:0]  seg_valid, seg_dsize;
    logic        smiact_release, ud_trap, nmi_trap, nmi_masked, nmi_pending;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    localparam logic [11:0] OFS [10] = '{12'h0F8, 12'h1FC, 12'h1F4, 12'h1F0,
        12'h1A8, 12'h138, 12'h1B0, 12'h150, 12'h1B4, 12'h15C};

    always #4 clk = ~clk;

    smm_resume_engine uut (.*);

    task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; rsm_cmd = 1'b0; in_smm = 1'b0; smbase_in = 32'h0003_0000;
        nmi_req = 1'b0; rd_valid = 1'b0; rd_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("reset rd_req", rd_req, 0);
        check("reset ld_strobe", ld_strobe, 0);
        check("reset traps", {ud_trap, nmi_trap}, 0);
        check("reset nmi state", {nmi_masked, nmi_pending}, 0);
    endtask

    // R1: resume outside management mode
    task automatic t_rsm_outside();
        rsm_cmd = 1'b1;
        @(negedge clk);
        rsm_cmd = 1'b0;
        check("R1 ud_trap raised", ud_trap, 1);
        check("R1 no read", rd_req, 0);
        @(negedge clk);
        check("R1 ud_trap single pulse", ud_trap, 0);
        check("R1 still no read", rd_req, 0);
    endtask

    // R11: unmasked NMI
    task automatic t_nmi_unmasked();
        nmi_req = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0;
        check("R11 nmi_trap immediate", nmi_trap, 1);
        check("R11 no pending", nmi_pending, 0);
        @(negedge clk);
        check("R11 nmi_trap single", nmi_trap, 0);
    endtask

    // R9: enter mode, mask set, masked NMI latches
    task automatic t_enter(input bit send_nmi);
        in_smm = 1'b1;
        @(negedge clk);
        check("R9 mask set on entry", nmi_masked, 1);
        if (send_nmi) begin
            nmi_req = 1'b1;
            @(negedge clk);
            nmi_req = 1'b0;
            check("R9 masked nmi no trap", nmi_trap, 0);
            check("R9 masked nmi latched", nmi_pending, 1);
            @(negedge clk);
            check("R9 still no trap", nmi_trap, 0);
        end
    endtask

    // R2, R3, R12: serve the read sequence; returns at the strobe cycle
    task automatic run_resume(input logic [31:0] base, input logic [31:0] v [10],
                              input int gap, input bit inject);
        smbase_in = base;
        rsm_cmd = 1'b1;
        @(negedge clk);
        rsm_cmd = 1'b0;
        smbase_in = 32'hDEAD_0000;
        for (int i = 0; i < 10; i++) begin
            int t = 0;
            while (!rd_req && t < 20) begin
                @(negedge clk);
                t++;
            end
            check("R3 request issued", rd_req, 1);
            check("R2 read address", rd_addr, base + 32'hFE00 + {20'h0, OFS[i]});
            if (inject && i == 3) rsm_cmd = 1'b1;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                if (rsm_cmd) begin
                    rsm_cmd = 1'b0;
                    check("R12 busy command no trap", ud_trap, 0);
                end
                check("R3 no second request while waiting", rd_req, 0);
            end
            rd_valid = 1'b1;
            rd_data  = v[i];
            @(negedge clk);
            rd_valid = 1'b0;
            rd_data  = '0;
        end
        check("R4 load strobe", ld_strobe, 1);
        check("R8 release pulse", smiact_release, 1);
        check("R4 new_smbase", new_smbase, v[0]);
        check("R4 new_cr0", new_cr0, v[1]);
        check("R4 new_eflags", new_eflags, v[2]);
        check("R4 new_eip", new_eip, v[3]);
        check("R4 seg_sel", seg_sel, {v[8][15:0], v[6][15:0], v[4][15:0]});
        check("R4 seg_attr", seg_attr, {v[9], v[7], v[5]});
    endtask

    task automatic t_resume_protected();
        logic [31:0] v [10] = '{32'h0004_0000, 32'h0000_0011, 32'h0000_0002, 32'h0000_1234,
            32'h0000_0000, 32'h0000_4093, 32'h0000_0010, 32'h0000_60F3,
            32'h0000_001B, 32'h0000_00F3};
        t_enter(1'b1);
        run_resume(32'h0003_0000, v, 1, 1'b1);
        check("R5 cpl from SS attr", new_cpl, 2'd3);
        check("R6 valid protected", seg_valid, 3'b110);
        check("R6 dsize protected", seg_dsize, 3'b011);
        in_smm = 1'b0;
        @(negedge clk);
        check("R4 strobe single", ld_strobe, 0);
        check("R8 mask cleared", nmi_masked, 0);
        check("R10 latched nmi replayed", nmi_trap, 1);
        check("R10 pending cleared", nmi_pending, 0);
        @(negedge clk);
        check("R10 replay single", nmi_trap, 0);
    endtask

    task automatic t_resume_real();
        logic [31:0] v [10] = '{32'h0005_0000, 32'h0000_0010, 32'h0000_0002, 32'h0000_8000,
            32'h0000_0000, 32'h0000_4093, 32'h0000_0000, 32'h0000_2093,
            32'h0000_0040, 32'h0000_4093};
        t_enter(1'b0);
        run_resume(32'h0004_0000, v, 3, 1'b0);
        check("R5 cpl real", new_cpl, 2'd1);
        check("R7 valid real", seg_valid, 3'b111);
        check("R7 dsize real", seg_dsize, 3'b000);
        in_smm = 1'b0;
        @(negedge clk);
        check("R10 no replay without pending", nmi_trap, 0);
        check("R8 mask cleared real", nmi_masked, 0);
    endtask

    task automatic t_resume_v86();
        logic [31:0] v [10] = '{32'h0003_0000, 32'h0000_0011, 32'h0002_0002, 32'h0000_0100,
            32'h0000_0000, 32'h0000_4093, 32'h0000_0000, 32'h0000_6093,
            32'h0000_0050, 32'h0000_4093};
        t_enter(1'b0);
        run_resume(32'h0005_0000, v, 2, 1'b0);
        check("R5 cpl v86", new_cpl, 2'd3);
        check("R7 valid v86", seg_valid, 3'b111);
        check("R7 dsize v86", seg_dsize, 3'b000);
        in_smm = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_rsm_outside();
        t_nmi_unmasked();
        t_resume_protected();
        t_resume_real();
        t_resume_v86();
        t_nmi_unmasked();
        t_rsm_outside();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule